// File: doc/BRIEF.md
# Store queue with load disambiguation

This block holds the stores that are in flight, in program order, between the moment they are issued and the moment they commit. A store takes a slot when it is issued, with only the tag of the instruction that will produce its data. Its address and its data then arrive later, each on its own fill port and in either order. Once the oldest store holds both, it is offered on the retire stream, and the commit logic takes it with a valid/ready handshake.

Loads use the queue to learn whether memory may be read. When a load issues, it copies the current tail position (`tail_pos`) as its age mark. When its address is known, it presents the mark and the address on the query port. The block then looks only at stores older than the mark and answers in the same cycle with one of four outcomes:
- stall;
- forward the store's value;
- forward the reorder tag of the value's producer;
- go to memory.

A flush input cuts the queue back to a given position, which discards every younger store.

Handshake rules:
- Allocation is a valid/ready stream. `alloc_ready` is low when the queue is full or a flush is being applied. A store is taken on a cycle in which both valid and ready are high.
- Retirement is a valid/ready stream. Once `ret_valid` is raised, it stays high with `ret_addr`/`ret_data` unchanged until `ret_ready` is seen, unless a flush removes that store.
- The fill ports and the query port have no back-pressure.

Top module: `store_queue`

## Requirements
- R1: A store is accepted when `alloc_valid` and `alloc_ready` are both high. It occupies slot `tail_pos[2:0]`, and `tail_pos` (a 4-bit position with a wrap bit) then advances by one. `sq_full` is high when 8 stores are held, and `alloc_ready` is low while `sq_full` is high.
- R2: An address fill or a data fill to a held slot makes that field valid. A second fill to a field that is already valid is ignored.
- R3: `ret_valid` is high when the oldest held store has both address and data. `ret_addr`/`ret_data` are that store's fields, and a handshake removes it. Once raised, `ret_valid` holds with stable fields until the handshake, unless a flush is applied.
- R4: A query whose older stores include one without an address returns outcome 01 (stall).
- R5: When the chosen matching older store has its data, the outcome is 10 and `ld_data` carries that data.
- R6: When the chosen matching older store lacks its data, the outcome is 11 and `ld_tag` carries its producer tag.
- R7: With no matching older store the outcome is 00 (memory). The outcome is also 00 when `ld_valid` is low. Stores at or after the load's mark are never considered. A mark up to 3 positions behind the oldest held store means no store is older.
- R8: When several older stores match the address, the youngest of them is chosen.
- R9: While `flush_valid` is high, `alloc_ready` is low, and on the next edge `tail_pos` becomes `flush_pos`, discarding every store at or after that position. `flush_pos` must lie between the oldest store that survives a same-cycle retirement and the tail.
- R10: After reset the queue is empty: `tail_pos` is 0, `sq_full` and `ret_valid` are low, and `alloc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Store issue request |
| alloc_ready | output | 1 | Store can be accepted |
| alloc_tag | input | TW | Reorder tag of the store data's producer |
| tail_pos | output | PW+1 | Position of the next store; also the load age mark |
| sq_full | output | 1 | All slots held |
| afill_valid | input | 1 | Address fill strobe |
| afill_slot | input | PW | Slot receiving the address |
| afill_addr | input | AW | Store address |
| dfill_valid | input | 1 | Data fill strobe |
| dfill_slot | input | PW | Slot receiving the data |
| dfill_data | input | DW | Store data |
| ret_valid | output | 1 | Oldest store is complete and can commit |
| ret_ready | input | 1 | Commit accepts the oldest store |
| ret_addr | output | AW | Address of the retiring store |
| ret_data | output | DW | Data of the retiring store |
| flush_valid | input | 1 | Flush request |
| flush_pos | input | PW+1 | First position to discard |
| ld_valid | input | 1 | Load query present |
| ld_mark | input | PW+1 | Tail position captured at load issue |
| ld_addr | input | AW | Load address |
| ld_result | output | 2 | 00 memory, 01 stall, 10 forward data, 11 forward tag |
| ld_data | output | DW | Forwarded store data |
| ld_tag | output | TW | Forwarded producer tag |

## Verification
The hardest case to reach is a query in which several older stores hold the same address and every older store already has its address. It is harder still when a younger matching store sits past the load's mark, which must not be picked. The stimulus draws addresses from only four values, favours address fills to stores that are already held, and swings between fill-heavy and drain-heavy phases, so the queue often holds many complete stores. Marks are drawn from anywhere between a little behind the oldest store and the tail, and a count of forwards decided among two or more matches confirms that the youngest-match rule was really exercised.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    LD_MEM      = 2'b00,
    LD_STALL    = 2'b01,
    LD_FWD_DATA = 2'b10,
    LD_FWD_TAG  = 2'b11
  } ld_outcome_e;
endpackage

// File: rtl/sq_ptr_ctrl.sv
module sq_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int PTRW = PW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic            flush,
  input  logic [PTRW-1:0] flush_pos,
  output logic [PTRW-1:0] head,
  output logic [PTRW-1:0] tail,
  output logic [PTRW-1:0] count,
  output logic            full,
  output logic [DEPTH-1:0] live
);
  // Head and tail carry one extra wrap bit so full and empty differ.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (pop) head <= head + PTRW'(1);
      if (flush) tail <= flush_pos;
      else if (push) tail <= tail + PTRW'(1);
    end
  end

  assign count = tail - head;
  assign full  = (count == PTRW'(DEPTH));

  // A slot is held when its age (distance from head) is below count.
  for (genvar g = 0; g < DEPTH; g++) begin : g_live
    logic [PW-1:0] age;
    assign age     = PW'(g) - head[PW-1:0];
    assign live[g] = ({1'b0, age} < count);
  end
endmodule

// File: rtl/sq_entry_array.sv
module sq_entry_array #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TW = 6,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_en,
  input  logic [PW-1:0]             alloc_slot,
  input  logic [TW-1:0]             alloc_tag,
  input  logic [DEPTH-1:0]          live,
  input  logic                      afill_en,
  input  logic [PW-1:0]             afill_slot,
  input  logic [AW-1:0]             afill_addr,
  input  logic                      dfill_en,
  input  logic [PW-1:0]             dfill_slot,
  input  logic [DW-1:0]             dfill_data,
  output logic [DEPTH-1:0]          addr_v,
  output logic [DEPTH-1:0][AW-1:0]  addr_q,
  output logic [DEPTH-1:0]          data_v,
  output logic [DEPTH-1:0][DW-1:0]  data_q,
  output logic [DEPTH-1:0][TW-1:0]  tag_q
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic          av_r, dv_r;
    logic [AW-1:0] a_r;
    logic [DW-1:0] d_r;
    logic [TW-1:0] t_r;
    logic          take, set_a, set_d;

    assign take  = alloc_en && (alloc_slot == PW'(g));
    // Fields are write-once: a fill lands only on a held slot whose field is still empty.
    assign set_a = afill_en && (afill_slot == PW'(g)) && live[g] && !av_r;
    assign set_d = dfill_en && (dfill_slot == PW'(g)) && live[g] && !dv_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        av_r <= 1'b0;
        dv_r <= 1'b0;
      end else if (take) begin
        av_r <= 1'b0;
        dv_r <= 1'b0;
      end else begin
        if (set_a) av_r <= 1'b1;
        if (set_d) dv_r <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (take)  t_r <= alloc_tag;
      if (set_a) a_r <= afill_addr;
      if (set_d) d_r <= dfill_data;
    end

    assign addr_v[g] = av_r;
    assign data_v[g] = dv_r;
    assign addr_q[g] = a_r;
    assign data_q[g] = d_r;
    assign tag_q[g]  = t_r;
  end
endmodule

// File: rtl/sq_load_search.sv
module sq_load_search
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TW = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int PTRW = PW + 1
) (
  input  logic [PTRW-1:0]           head,
  input  logic [PTRW-1:0]           count,
  input  logic                      ld_valid,
  input  logic [PTRW-1:0]           ld_mark,
  input  logic [AW-1:0]             ld_addr,
  input  logic [DEPTH-1:0]          addr_v,
  input  logic [DEPTH-1:0][AW-1:0]  addr_q,
  input  logic [DEPTH-1:0]          data_v,
  input  logic [DEPTH-1:0][DW-1:0]  data_q,
  input  logic [DEPTH-1:0][TW-1:0]  tag_q,
  output ld_outcome_e               result,
  output logic [DW-1:0]             fwd_data,
  output logic [TW-1:0]             fwd_tag
);
  logic [PTRW-1:0] diff, older_n;
  logic [PW-1:0]   slot;
  logic            stall, hit, hit_dv;
  logic [DW-1:0]   hit_d;
  logic [TW-1:0]   hit_t;

  always_comb begin
    // A mark behind head wraps to a distance beyond count: nothing is older.
    diff    = ld_mark - head;
    older_n = (diff > count) ? '0 : diff;
    stall   = 1'b0;
    hit     = 1'b0;
    hit_dv  = 1'b0;
    hit_d   = '0;
    hit_t   = '0;
    slot    = '0;
    // Walk oldest to youngest; a later match overrides, so the youngest wins.
    for (int k = 0; k < DEPTH; k++) begin
      slot = head[PW-1:0] + PW'(k);
      if (PTRW'(k) < older_n) begin
        if (!addr_v[slot]) begin
          stall = 1'b1;
        end else if (addr_q[slot] == ld_addr) begin
          hit    = 1'b1;
          hit_dv = data_v[slot];
          hit_d  = data_q[slot];
          hit_t  = tag_q[slot];
        end
      end
    end
  end

  always_comb begin
    result   = LD_MEM;
    fwd_data = '0;
    fwd_tag  = '0;
    if (ld_valid) begin
      if (stall) begin
        result = LD_STALL;
      end else if (hit && hit_dv) begin
        result   = LD_FWD_DATA;
        fwd_data = hit_d;
      end else if (hit) begin
        result  = LD_FWD_TAG;
        fwd_tag = hit_t;
      end
    end
  end
endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TW = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int PTRW = PW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_valid,
  output logic            alloc_ready,
  input  logic [TW-1:0]   alloc_tag,
  output logic [PTRW-1:0] tail_pos,
  output logic            sq_full,
  input  logic            afill_valid,
  input  logic [PW-1:0]   afill_slot,
  input  logic [AW-1:0]   afill_addr,
  input  logic            dfill_valid,
  input  logic [PW-1:0]   dfill_slot,
  input  logic [DW-1:0]   dfill_data,
  output logic            ret_valid,
  input  logic            ret_ready,
  output logic [AW-1:0]   ret_addr,
  output logic [DW-1:0]   ret_data,
  input  logic            flush_valid,
  input  logic [PTRW-1:0] flush_pos,
  input  logic            ld_valid,
  input  logic [PTRW-1:0] ld_mark,
  input  logic [AW-1:0]   ld_addr,
  output logic [1:0]      ld_result,
  output logic [DW-1:0]   ld_data,
  output logic [TW-1:0]   ld_tag
);
  logic [PTRW-1:0]          head, tail, count;
  logic                     full, push, pop;
  logic [DEPTH-1:0]         live, addr_v, data_v;
  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0][TW-1:0] tag_q;
  logic [PW-1:0]            hslot;
  ld_outcome_e              outcome;

  assign alloc_ready = !full && !flush_valid;
  assign push        = alloc_valid && alloc_ready;
  assign hslot       = head[PW-1:0];
  assign ret_valid   = (count != '0) && addr_v[hslot] && data_v[hslot];
  assign pop         = ret_valid && ret_ready;
  assign ret_addr    = addr_q[hslot];
  assign ret_data    = data_q[hslot];
  assign tail_pos    = tail;
  assign sq_full     = full;
  assign ld_result   = outcome;

  sq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .flush(flush_valid), .flush_pos(flush_pos),
    .head(head), .tail(tail), .count(count), .full(full), .live(live)
  );

  sq_entry_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(push), .alloc_slot(tail[PW-1:0]), .alloc_tag(alloc_tag),
    .live(live),
    .afill_en(afill_valid), .afill_slot(afill_slot), .afill_addr(afill_addr),
    .dfill_en(dfill_valid), .dfill_slot(dfill_slot), .dfill_data(dfill_data),
    .addr_v(addr_v), .addr_q(addr_q), .data_v(data_v), .data_q(data_q),
    .tag_q(tag_q)
  );

  sq_load_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) u_search (
    .head(head), .count(count), .ld_valid(ld_valid), .ld_mark(ld_mark),
    .ld_addr(ld_addr), .addr_v(addr_v), .addr_q(addr_q), .data_v(data_v),
    .data_q(data_q), .tag_q(tag_q),
    .result(outcome), .fwd_data(ld_data), .fwd_tag(ld_tag)
  );
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int TW = 6,
  localparam int PW = $clog2(DEPTH),
  localparam int PTRW = PW + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            alloc_valid,
  input logic            alloc_ready,
  input logic [PTRW-1:0] tail_pos,
  input logic            sq_full,
  input logic            ret_valid,
  input logic            ret_ready,
  input logic [AW-1:0]   ret_addr,
  input logic [DW-1:0]   ret_data,
  input logic            flush_valid,
  input logic [PTRW-1:0] flush_pos,
  input logic            ld_valid,
  input logic [1:0]      ld_result
);
  p_full_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sq_full |-> !alloc_ready);

  p_tail_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (tail_pos == $past(tail_pos) + PTRW'(1)));

  p_ret_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_ready && !flush_valid) |=>
      (ret_valid && $stable(ret_addr) && $stable(ret_data)));

  p_flush_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (tail_pos == $past(flush_pos)));

  p_flush_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !alloc_ready);

  p_idle_mem_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> (ld_result == 2'b00));
endmodule

bind store_queue sq_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) u_chk (.*);

// File: tb/sim_store_queue.sv
module sim_store_queue;
  localparam int DEPTH = 8, AW = 32, DW = 32, TW = 6, PW = 3, PTRW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, alloc_valid, alloc_ready, sq_full, afill_valid, dfill_valid;
  logic ret_valid, ret_ready, flush_valid, ld_valid;
  logic [TW-1:0] alloc_tag, ld_tag;
  logic [PTRW-1:0] tail_pos, flush_pos, ld_mark;
  logic [PW-1:0] afill_slot, dfill_slot;
  logic [AW-1:0] afill_addr, ret_addr, ld_addr;
  logic [DW-1:0] dfill_data, ret_data, ld_data;
  logic [1:0] ld_result;

  store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) u0 (.*);

  typedef struct {
    logic [31:0] a; bit av;
    logic [31:0] d; bit dv;
    logic [5:0] t;
  } ment_t;
  ment_t mq[$];
  int hd;
  int n_chk, n_fail;
  bit done;
  int seen[4];
  int seen_multi, seen_full, seen_flush, seen_refill;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pick_addr();
    return 32'h100 + 32'($urandom_range(0, 3)) * 4;
  endfunction

  function automatic int wrap16(input int v);
    return ((v % 16) + 16) % 16;
  endfunction

  // Expected query answer from the reference list of held stores.
  task automatic ld_expect(input int mark_abs, input logic [31:0] a, output logic [1:0] r,
                           output logic [31:0] d, output logic [5:0] t, output int nmatch);
    int older;
    bit stall;
    int pick;
    older = mark_abs - hd;
    if (older < 0) older = 0;
    if (older > mq.size()) older = mq.size();
    stall = 0; pick = -1; nmatch = 0; d = '0; t = '0;
    for (int j = 0; j < older; j++) begin
      if (!mq[j].av) stall = 1;
      else if (mq[j].a == a) begin pick = j; nmatch++; end
    end
    if (stall) r = 2'b01;
    else if (pick < 0) r = 2'b00;
    else if (mq[pick].dv) begin r = 2'b10; d = mq[pick].d; end
    else begin r = 2'b11; t = mq[pick].t; end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired before the run ended");
      summary();
      $finish;
    end
  end

  initial begin
    int sz, mark_abs, flush_abs, lo, phase, nm, age, pa, pr;
    bit exp_rv, do_pop;
    logic [1:0] er;
    logic [31:0] ed;
    logic [5:0] et;

    rst_n = 0; alloc_valid = 0; alloc_tag = 0; afill_valid = 0; afill_slot = 0;
    afill_addr = 0; dfill_valid = 0; dfill_slot = 0; dfill_data = 0; ret_ready = 0;
    flush_valid = 0; flush_pos = 0; ld_valid = 0; ld_mark = 0; ld_addr = 0;
    hd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(tail_pos == 0, "R10 tail_pos after reset", 64'(tail_pos), 0);
    chk(!sq_full, "R10 sq_full after reset", 64'(sq_full), 0);
    chk(!ret_valid, "R10 ret_valid after reset", 64'(ret_valid), 0);
    chk(alloc_ready, "R10 alloc_ready after reset", 64'(alloc_ready), 1);
    chk(ld_result == 2'b00, "R7 idle query after reset", 64'(ld_result), 0);

    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      sz = mq.size();
      phase = (c / 250) % 3;
      pa = (phase == 0) ? 90 : (phase == 1) ? 15 : 55;
      pr = (phase == 0) ? 10 : (phase == 1) ? 85 : 45;
      exp_rv = (sz > 0) && mq[0].av && mq[0].dv;

      alloc_valid = ($urandom_range(0, 99) < pa);
      alloc_tag = 6'($urandom);
      ret_ready = ($urandom_range(0, 99) < pr);
      do_pop = exp_rv && ret_ready;

      afill_valid = ($urandom_range(0, 99) < 45);
      if (sz > 0 && $urandom_range(0, 9) < 8) afill_slot = 3'(wrap16(hd + $urandom_range(0, sz - 1)));
      else afill_slot = 3'($urandom);
      afill_addr = pick_addr();
      dfill_valid = ($urandom_range(0, 99) < 40);
      if (sz > 0 && $urandom_range(0, 9) < 8) dfill_slot = 3'(wrap16(hd + $urandom_range(0, sz - 1)));
      else dfill_slot = 3'($urandom);
      dfill_data = $urandom;

      flush_valid = ($urandom_range(0, 99) < 3);
      lo = hd + (do_pop ? 1 : 0);
      flush_abs = lo + $urandom_range(0, hd + sz - lo);
      flush_pos = 4'(wrap16(flush_abs));

      ld_valid = ($urandom_range(0, 99) < 75);
      mark_abs = hd + sz - $urandom_range(0, sz + 3);
      ld_mark = 4'(wrap16(mark_abs));
      ld_addr = pick_addr();
      #1;

      chk(sq_full == (sz == 8), "R1 sq_full", 64'(sq_full), 64'(sz == 8));
      chk(alloc_ready == (sz < 8 && !flush_valid), "R1/R9 alloc_ready", 64'(alloc_ready),
          64'(sz < 8 && !flush_valid));
      chk(tail_pos == 4'(wrap16(hd + sz)), "R1 tail_pos", 64'(tail_pos), 64'(wrap16(hd + sz)));
      chk(ret_valid == exp_rv, "R3 ret_valid", 64'(ret_valid), 64'(exp_rv));
      if (exp_rv) begin
        chk(ret_addr == mq[0].a, "R2/R3 ret_addr", 64'(ret_addr), 64'(mq[0].a));
        chk(ret_data == mq[0].d, "R2/R3 ret_data", 64'(ret_data), 64'(mq[0].d));
      end
      if (ld_valid) ld_expect(mark_abs, ld_addr, er, ed, et, nm);
      else begin er = 2'b00; ed = 0; et = 0; nm = 0; end
      case (er)
        2'b01: chk(ld_result == er, "R4 stall on older unknown address", 64'(ld_result), 64'(er));
        2'b10: begin
          chk(ld_result == er, "R5 forward data outcome", 64'(ld_result), 64'(er));
          chk(ld_data == ed, nm > 1 ? "R8 youngest match data" : "R5 forwarded data",
              64'(ld_data), 64'(ed));
        end
        2'b11: begin
          chk(ld_result == er, "R6 forward tag outcome", 64'(ld_result), 64'(er));
          chk(ld_tag == et, nm > 1 ? "R8 youngest match tag" : "R6 forwarded tag",
              64'(ld_tag), 64'(et));
        end
        default: chk(ld_result == er, "R7 memory outcome", 64'(ld_result), 64'(er));
      endcase
      if (ld_valid) seen[er]++;
      if (ld_valid && nm > 1 && er[1]) seen_multi++;
      if (sz == 8) seen_full++;

      @(posedge clk);
      // Fills land on held entries whose field is still empty.
      if (afill_valid) begin
        age = wrap16(int'(afill_slot) - hd) % 8;
        if (age < sz) begin
          if (!mq[age].av) begin mq[age].av = 1; mq[age].a = afill_addr; end
          else seen_refill++;
        end
      end
      if (dfill_valid) begin
        age = wrap16(int'(dfill_slot) - hd) % 8;
        if (age < sz) begin
          if (!mq[age].dv) begin mq[age].dv = 1; mq[age].d = dfill_data; end
          else seen_refill++;
        end
      end
      if (do_pop) begin void'(mq.pop_front()); hd++; end
      if (flush_valid) begin
        seen_flush++;
        while (hd + mq.size() > flush_abs) void'(mq.pop_back());
      end else if (alloc_valid && sz < 8) begin
        mq.push_back('{a: 0, av: 0, d: 0, dv: 0, t: alloc_tag});
      end
    end

    chk(seen_full > 0, "R1 queue reached full", 64'(seen_full), 1);
    chk(seen_refill > 0, "R2 refill of valid field exercised", 64'(seen_refill), 1);
    chk(seen[1] > 0, "R4 stall outcome exercised", 64'(seen[1]), 1);
    chk(seen[2] > 0, "R5 data forward exercised", 64'(seen[2]), 1);
    chk(seen[3] > 0, "R6 tag forward exercised", 64'(seen[3]), 1);
    chk(seen[0] > 0, "R7 memory outcome exercised", 64'(seen[0]), 1);
    chk(seen_multi > 0, "R8 multiple older matches exercised", 64'(seen_multi), 1);
    chk(seen_flush > 0, "R9 flush exercised", 64'(seen_flush), 1);
    done = 1;
    summary();
    $finish;
  end
endmodule